// File: doc/BRIEF.md
# Colour Sensor Command Register Interface

This block is the register-access front end of a four-channel colour light sensor. It sits behind a byte-level serial slave engine. That engine hands it one byte at a time and signals where each write transaction starts. The first byte written after a transaction start is a command byte. The block decodes this byte into a register pointer and an access mode. Every later byte in the transaction, and every byte read, goes to the register at the pointer.

There are three access modes. Single access keeps the pointer fixed. Auto-increment access steps the pointer after every data byte, so a 16-bit threshold or result can be moved in one burst. A special-function command leaves the pointer alone and clears the pending interrupt flag.

The measurement engine supplies the four 16-bit results (clear, red, green, blue) through a strobe. Reading the low byte of a result captures its high byte, so a two-byte read stays coherent even if a new measurement lands between the two bytes. The configuration registers drive the rest of the sensor directly, including a decoded analog gain factor.

Top module: `als_cmd_regif`

## Requirements
- R1: After `xfer_start_i`, the first written byte with bit 7 = 1 is the command byte. A byte with bit 7 = 0 in that position is ignored, and the next written byte is again taken as the command.
- R2: For a command with mode bits 6:5 equal to 00, 01 or 10, bits 4:0 are loaded into the pointer. The following written bytes of the transaction go to the register at the pointer.
- R3: With mode 00 or 10, the pointer does not move on data reads or data writes.
- R4: With mode 01, the pointer increments by one after each data byte read or written, and wraps from 0x1F to 0x00.
- R5: 16-bit registers place the low byte at the even address and the high byte at the odd address. The low threshold is at 0x04/0x05 and the high threshold at 0x06/0x07. The results are at 0x14 (clear, `meas_data_i[15:0]`), 0x16 (red, `[31:16]`), 0x18 (green, `[47:32]`) and 0x1A (blue, `[63:48]`). Results are loaded when `meas_valid_i` is high.
- R6: Mode 11 is a special function and does not change the pointer. Code 0x06 (command byte 0xE6) clears the interrupt flag. Other codes have no effect. `int_set_i` sets the flag, and a set in the same cycle as a clear wins.
- R7: Address 0x12 reads 0x44. Address 0x13 reads the interrupt flag in bit 4 and, in bit 0, a valid bit that is set by the first `meas_valid_i` after reset and then stays set. Both addresses ignore writes.
- R8: Reading the low byte of a result captures that result's high byte. A later read of the high-byte address returns the captured byte, even if the result has been updated in between.
- R9: Addresses outside the map read as 0x00, and writes to them change no register.
- R10: Bits 1:0 of the control register (0x0F) select `gain_o` as 1, 4, 16 or 60 for codes 0, 1, 2 and 3.
- R11: Reset values:
  - enable, wait-free registers: persistence, config and control at 0x00
  - integration time and wait time at 0xFF
  - both thresholds at 0x0000
  - results at 0x0000
  - interrupt flag and valid bit at 0
  - pointer at 0x00, in single mode
- R12: The registers at 0x00, 0x01, 0x03, 0x04 to 0x07, 0x0C, 0x0D and 0x0F read back the last byte written and drive the matching outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xfer_start_i | input | 1 | Pulse: a new write transaction starts, so the next written byte is a command |
| wr_en_i | input | 1 | A written byte is present |
| wr_data_i | input | 8 | Written byte |
| rd_en_i | input | 1 | Byte is consumed by a read; advances the pointer in auto mode |
| rd_data_o | output | 8 | Byte at the current pointer |
| meas_valid_i | input | 1 | New results present |
| meas_data_i | input | 64 | Results: clear, red, green, blue, starting from the LSB |
| int_set_i | input | 1 | Interrupt condition from the threshold logic |
| enable_o | output | 8 | Enable register |
| int_time_o | output | 8 | Integration time register |
| wait_time_o | output | 8 | Wait time register |
| thr_lo_o | output | 16 | Low threshold |
| thr_hi_o | output | 16 | High threshold |
| persist_o | output | 8 | Persistence register |
| config_o | output | 8 | Configuration register |
| gain_o | output | 6 | Decoded gain factor |
| int_flag_o | output | 1 | Pending interrupt flag |

## Verification
Directed sequences cover the cases that separate the modes:
- A single-mode command followed by repeated reads, which shows that the pointer holds.
- An auto burst over both thresholds, which shows stepping and byte order.
- A burst starting at 0x1F, which shows the wrap.
- A leading byte with bit 7 clear, which shows command recognition.
- 0xE6 against a different special code.
- A result read with a new measurement slipped between its two bytes, which shows the captured high byte rather than the live one.

Seeded random sequences then mix single and auto commands, measurements, interrupt events and special functions. Every byte read and every output is compared against a register model in the bench. This catches wrong address decoding, lost read-only protection and wrong gain decoding across the whole map.

// File: rtl/als_regif_pkg.sv
package als_regif_pkg;
  localparam int ADDR_W = 5;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    MODE_SINGLE  = 2'b00,
    MODE_AUTO    = 2'b01,
    MODE_RSVD    = 2'b10,
    MODE_SPECIAL = 2'b11
  } mode_e;

  typedef struct packed {
    logic  is_cmd;
    mode_e mode;
    addr_t field;
  } cmd_t;

  localparam addr_t A_ENABLE = 5'h00;
  localparam addr_t A_ITIME  = 5'h01;
  localparam addr_t A_WTIME  = 5'h03;
  localparam addr_t A_THLO_L = 5'h04;
  localparam addr_t A_THLO_H = 5'h05;
  localparam addr_t A_THHI_L = 5'h06;
  localparam addr_t A_THHI_H = 5'h07;
  localparam addr_t A_PERS   = 5'h0C;
  localparam addr_t A_CFG    = 5'h0D;
  localparam addr_t A_CTRL   = 5'h0F;
  localparam addr_t A_ID     = 5'h12;
  localparam addr_t A_STAT   = 5'h13;
  localparam addr_t A_RES    = 5'h14;

  localparam addr_t SF_INT_CLR = 5'h06;
endpackage

// File: rtl/als_cmd_decode.sv
module als_cmd_decode
  import als_regif_pkg::*;
(
  input  logic [7:0] byte_i,
  output cmd_t       cmd_o
);
  always_comb begin
    cmd_o.is_cmd = byte_i[7];
    cmd_o.mode   = mode_e'(byte_i[6:5]);
    cmd_o.field  = byte_i[ADDR_W-1:0];
  end
endmodule

// File: rtl/als_ptr_ctrl.sv
module als_ptr_ctrl
  import als_regif_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  wr_en_i,
  input  logic  rd_en_i,
  input  cmd_t  cmd_i,
  output addr_t ptr_o,
  output logic  data_wr_o,
  output logic  data_rd_o,
  output logic  int_clr_o
);
  logic  expect_q, auto_q;
  addr_t ptr_q;
  logic  cmd_byte, cmd_ok, is_sf, load, step;

  assign cmd_byte  = wr_en_i & expect_q;
  assign cmd_ok    = cmd_byte & cmd_i.is_cmd;
  assign is_sf     = (cmd_i.mode == MODE_SPECIAL);
  assign load      = cmd_ok & ~is_sf;
  assign data_wr_o = wr_en_i & ~expect_q;
  assign data_rd_o = rd_en_i & ~wr_en_i;   // write wins a shared cycle
  assign int_clr_o = cmd_ok & is_sf & (cmd_i.field == SF_INT_CLR);
  assign step      = auto_q & (data_wr_o | data_rd_o);
  assign ptr_o     = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      expect_q <= 1'b1;
      auto_q   <= 1'b0;
      ptr_q    <= '0;
    end else begin
      if (start_i)     expect_q <= 1'b1;
      else if (cmd_ok) expect_q <= 1'b0;
      if (load) begin
        ptr_q  <= cmd_i.field;
        auto_q <= (cmd_i.mode == MODE_AUTO);
      end else if (step) begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  // R1
  nocmd_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_byte && !cmd_i.is_cmd && !start_i) |=> (expect_q && ptr_q == $past(ptr_q)));
  // R3
  single_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!auto_q && !load) |=> $stable(ptr_q));
  // R4
  auto_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_q && (data_rd_o || data_wr_o)) |=> (ptr_q == addr_t'($past(ptr_q) + 1'b1)));
  // R6
  sf_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_ok && is_sf) |=> $stable(ptr_q));
endmodule

// File: rtl/als_reg_file.sv
module als_reg_file
  import als_regif_pkg::*;
#(
  parameter int         NUM_CH    = 4,
  parameter logic [7:0] ID_VALUE  = 8'h44,
  parameter logic [7:0] ITIME_RST = 8'hFF,
  parameter logic [7:0] WTIME_RST = 8'hFF
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  addr_t                  ptr_i,
  input  logic                   wr_i,
  input  logic [7:0]             wdata_i,
  input  logic                   rd_i,
  input  logic                   int_clr_i,
  input  logic                   int_set_i,
  input  logic                   meas_valid_i,
  input  logic [NUM_CH*16-1:0]   meas_data_i,
  output logic [7:0]             rd_data_o,
  output logic [7:0]             enable_o,
  output logic [7:0]             itime_o,
  output logic [7:0]             wtime_o,
  output logic [15:0]            thlo_o,
  output logic [15:0]            thhi_o,
  output logic [7:0]             pers_o,
  output logic [7:0]             cfg_o,
  output logic [5:0]             gain_o,
  output logic                   int_flag_o
);
  localparam int RES_W = 16;

  logic [7:0]       enable_q, itime_q, wtime_q, pers_q, cfg_q, ctrl_q;
  logic [15:0]      thlo_q, thhi_q;
  logic             flag_q, valid_q;
  logic [RES_W-1:0] res_q [NUM_CH];
  logic [7:0]       sh_q  [NUM_CH];
  logic [NUM_CH-1:0] lo_hit, hi_hit;
  logic             wr_hit;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_res_addr
    localparam addr_t LO = A_RES + addr_t'(2 * g);
    assign lo_hit[g] = (ptr_i == LO);
    assign hi_hit[g] = (ptr_i == LO + addr_t'(1));
  end

  assign wr_hit = ptr_i inside {A_ENABLE, A_ITIME, A_WTIME, A_THLO_L, A_THLO_H,
                                A_THHI_L, A_THHI_H, A_PERS, A_CFG, A_CTRL};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q <= '0;
      itime_q  <= ITIME_RST;
      wtime_q  <= WTIME_RST;
      thlo_q   <= '0;
      thhi_q   <= '0;
      pers_q   <= '0;
      cfg_q    <= '0;
      ctrl_q   <= '0;
    end else if (wr_i) begin
      case (ptr_i)
        A_ENABLE: enable_q       <= wdata_i;
        A_ITIME:  itime_q        <= wdata_i;
        A_WTIME:  wtime_q        <= wdata_i;
        A_THLO_L: thlo_q[7:0]    <= wdata_i;
        A_THLO_H: thlo_q[15:8]   <= wdata_i;
        A_THHI_L: thhi_q[7:0]    <= wdata_i;
        A_THHI_H: thhi_q[15:8]   <= wdata_i;
        A_PERS:   pers_q         <= wdata_i;
        A_CFG:    cfg_q          <= wdata_i;
        A_CTRL:   ctrl_q         <= wdata_i;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_CH; i++) begin
        res_q[i] <= '0;
        sh_q[i]  <= '0;
      end
      valid_q <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (rd_i && lo_hit[i]) sh_q[i] <= res_q[i][15:8];
        if (meas_valid_i) res_q[i] <= meas_data_i[i*RES_W +: RES_W];
      end
      if (meas_valid_i) valid_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flag_q <= 1'b0;
    else if (int_set_i) flag_q <= 1'b1;
    else if (int_clr_i) flag_q <= 1'b0;
  end

  always_comb begin
    rd_data_o = '0;
    case (ptr_i)
      A_ENABLE: rd_data_o = enable_q;
      A_ITIME:  rd_data_o = itime_q;
      A_WTIME:  rd_data_o = wtime_q;
      A_THLO_L: rd_data_o = thlo_q[7:0];
      A_THLO_H: rd_data_o = thlo_q[15:8];
      A_THHI_L: rd_data_o = thhi_q[7:0];
      A_THHI_H: rd_data_o = thhi_q[15:8];
      A_PERS:   rd_data_o = pers_q;
      A_CFG:    rd_data_o = cfg_q;
      A_CTRL:   rd_data_o = ctrl_q;
      A_ID:     rd_data_o = ID_VALUE;
      A_STAT:   rd_data_o = {3'b000, flag_q, 3'b000, valid_q};
      default:  ;
    endcase
    for (int i = 0; i < NUM_CH; i++) begin
      if (lo_hit[i]) rd_data_o = res_q[i][7:0];
      if (hi_hit[i]) rd_data_o = sh_q[i];
    end
  end

  always_comb begin
    case (ctrl_q[1:0])
      2'd0:    gain_o = 6'd1;
      2'd1:    gain_o = 6'd4;
      2'd2:    gain_o = 6'd16;
      default: gain_o = 6'd60;
    endcase
  end

  assign enable_o   = enable_q;
  assign itime_o    = itime_q;
  assign wtime_o    = wtime_q;
  assign thlo_o     = thlo_q;
  assign thhi_o     = thhi_q;
  assign pers_o     = pers_q;
  assign cfg_o      = cfg_q;
  assign int_flag_o = flag_q;

  // R6
  int_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_clr_i && !int_set_i) |=> !flag_q);
  // R6
  int_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_set_i |=> flag_q);
  // R9
  unmapped_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wr_hit) |=> ($stable(enable_q) && $stable(itime_q) && $stable(wtime_q) &&
                           $stable(thlo_q) && $stable(thhi_q) && $stable(pers_q) &&
                           $stable(cfg_q) && $stable(ctrl_q)));
  // R8
  shadow_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && lo_hit[0]) |=> (sh_q[0] == $past(res_q[0][15:8])));
endmodule

// File: rtl/als_cmd_regif.sv
module als_cmd_regif
  import als_regif_pkg::*;
#(
  parameter int         NUM_CH    = 4,
  parameter logic [7:0] ID_VALUE  = 8'h44,
  parameter logic [7:0] ITIME_RST = 8'hFF,
  parameter logic [7:0] WTIME_RST = 8'hFF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 xfer_start_i,
  input  logic                 wr_en_i,
  input  logic [7:0]           wr_data_i,
  input  logic                 rd_en_i,
  output logic [7:0]           rd_data_o,
  input  logic                 meas_valid_i,
  input  logic [NUM_CH*16-1:0] meas_data_i,
  input  logic                 int_set_i,
  output logic [7:0]           enable_o,
  output logic [7:0]           int_time_o,
  output logic [7:0]           wait_time_o,
  output logic [15:0]          thr_lo_o,
  output logic [15:0]          thr_hi_o,
  output logic [7:0]           persist_o,
  output logic [7:0]           config_o,
  output logic [5:0]           gain_o,
  output logic                 int_flag_o
);
  cmd_t  cmd;
  addr_t ptr;
  logic  data_wr, data_rd, int_clr;

  als_cmd_decode u_dec (
    .byte_i (wr_data_i),
    .cmd_o  (cmd)
  );

  als_ptr_ctrl u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (xfer_start_i),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .cmd_i     (cmd),
    .ptr_o     (ptr),
    .data_wr_o (data_wr),
    .data_rd_o (data_rd),
    .int_clr_o (int_clr)
  );

  als_reg_file #(
    .NUM_CH    (NUM_CH),
    .ID_VALUE  (ID_VALUE),
    .ITIME_RST (ITIME_RST),
    .WTIME_RST (WTIME_RST)
  ) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ptr_i        (ptr),
    .wr_i         (data_wr),
    .wdata_i      (wr_data_i),
    .rd_i         (data_rd),
    .int_clr_i    (int_clr),
    .int_set_i    (int_set_i),
    .meas_valid_i (meas_valid_i),
    .meas_data_i  (meas_data_i),
    .rd_data_o    (rd_data_o),
    .enable_o     (enable_o),
    .itime_o      (int_time_o),
    .wtime_o      (wait_time_o),
    .thlo_o       (thr_lo_o),
    .thhi_o       (thr_hi_o),
    .pers_o       (persist_o),
    .cfg_o        (config_o),
    .gain_o       (gain_o),
    .int_flag_o   (int_flag_o)
  );
endmodule

// File: tb/als_cmd_regif_tb_top.sv
module als_cmd_regif_tb_top;
  localparam int NCH = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic start = 1'b0, wr_en = 1'b0, rd_en = 1'b0, meas_v = 1'b0, int_set = 1'b0;
  logic [7:0] wr_data = '0;
  logic [NCH*16-1:0] meas_d = '0;
  logic [7:0] rd_data, en_o, it_o, wt_o, ps_o, cf_o;
  logic [15:0] tl_o, th_o;
  logic [5:0] gain;
  logic flag;

  als_cmd_regif dut_i (
    .clk_i(clk), .rst_ni(rst_n), .xfer_start_i(start), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .meas_valid_i(meas_v), .meas_data_i(meas_d), .int_set_i(int_set),
    .enable_o(en_o), .int_time_o(it_o), .wait_time_o(wt_o), .thr_lo_o(tl_o),
    .thr_hi_o(th_o), .persist_o(ps_o), .config_o(cf_o), .gain_o(gain),
    .int_flag_o(flag)
  );

  int errs = 0, checks = 0;
  bit done = 1'b0;

  logic [7:0]  m_reg [32];
  logic [15:0] m_res [NCH];
  logic [7:0]  m_sh  [NCH];
  logic        m_flag = 1'b0, m_valid = 1'b0, m_expect = 1'b1, m_auto = 1'b0;
  logic [4:0]  m_ptr = '0;

  function automatic bit is_wr(int a);
    return a inside {0, 1, 3, 4, 5, 6, 7, 12, 13, 15};
  endfunction

  function automatic logic [7:0] exp_rd(int a);
    if (is_wr(a)) return m_reg[a];
    if (a == 'h12) return 8'h44;
    if (a == 'h13) return {3'b0, m_flag, 3'b0, m_valid};
    if (a >= 'h14 && a < 'h14 + 2*NCH) begin
      if (a[0]) return m_sh[(a - 'h14) / 2];
      return m_res[(a - 'h14) / 2][7:0];
    end
    return 8'h00;
  endfunction

  function automatic int gain_of(logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 16;
      default: return 60;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic t_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    m_expect = 1'b1;
  endtask

  task automatic t_byte(logic [7:0] b);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
    if (m_expect) begin
      if (b[7]) begin
        m_expect = 1'b0;
        if (b[6:5] == 2'b11) begin
          if (b[4:0] == 5'h06 && !int_set) m_flag = 1'b0;
        end else begin
          m_ptr = b[4:0];
          m_auto = (b[6:5] == 2'b01);
        end
      end
    end else begin
      if (is_wr(m_ptr)) m_reg[m_ptr] = b;
      if (m_auto) m_ptr = m_ptr + 1'b1;
    end
  endtask

  task automatic t_cmd(logic [7:0] b);
    t_start();
    t_byte(b);
  endtask

  task automatic t_rdat(string req);
    logic [7:0] v;
    rd_en = 1'b1;
    #1 v = rd_data;
    chk(req, v, exp_rd(m_ptr));
    @(negedge clk);
    rd_en = 1'b0;
    if (m_ptr >= 'h14 && m_ptr < 'h14 + 2*NCH && !m_ptr[0])
      m_sh[(m_ptr - 'h14) / 2] = m_res[(m_ptr - 'h14) / 2][15:8];
    if (m_auto) m_ptr = m_ptr + 1'b1;
  endtask

  task automatic t_meas(logic [NCH*16-1:0] d);
    meas_v = 1'b1; meas_d = d;
    @(negedge clk);
    meas_v = 1'b0;
    for (int i = 0; i < NCH; i++) m_res[i] = d[i*16 +: 16];
    m_valid = 1'b1;
  endtask

  task automatic t_int();
    int_set = 1'b1;
    @(negedge clk);
    int_set = 1'b0;
    m_flag = 1'b1;
  endtask

  task automatic chk_outs(string req);
    chk({req, " enable"}, en_o, m_reg[0]);
    chk({req, " itime"},  it_o, m_reg[1]);
    chk({req, " wtime"},  wt_o, m_reg[3]);
    chk({req, " thlo"},   tl_o, {m_reg[5], m_reg[4]});
    chk({req, " thhi"},   th_o, {m_reg[7], m_reg[6]});
    chk({req, " pers"},   ps_o, m_reg[12]);
    chk({req, " cfg"},    cf_o, m_reg[13]);
    chk({req, " R10 gain"}, gain, gain_of(m_reg[15][1:0]));
    chk({req, " flag"},   flag, m_flag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] old_clear;
    void'($urandom(32'd2024));
    for (int i = 0; i < 32; i++) m_reg[i] = 8'h00;
    m_reg[1] = 8'hFF; m_reg[3] = 8'hFF;
    for (int i = 0; i < NCH; i++) begin m_res[i] = '0; m_sh[i] = '0; end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk_outs("R11 reset");
    chk("R11 rd at ptr 0", rd_data, 8'h00);

    // R2 R3 single access
    t_cmd(8'h81); t_byte(8'h40);
    chk("R2 itime write", it_o, 8'h40);
    t_rdat("R3 single read 1"); t_rdat("R3 single read 2");
    chk("R3 ptr held", m_ptr, 5'h01);

    // R4 R5 auto burst over thresholds
    t_cmd(8'hA4);
    t_byte(8'h11); t_byte(8'h22); t_byte(8'h33); t_byte(8'h44);
    chk("R5 thr_lo order", tl_o, 16'h2211);
    chk("R5 thr_hi order", th_o, 16'h4433);
    t_cmd(8'hA4);
    for (int i = 0; i < 4; i++) t_rdat("R4 auto readback");

    // R4 wrap 0x1F -> 0x00
    t_cmd(8'h80); t_byte(8'h5C);
    t_cmd(8'hBF); t_rdat("R9 unmapped 0x1F"); t_rdat("R4 wrap to enable");
    chk("R4 wrap read", exp_rd(0), 8'h5C);

    // R1 non-command leading byte
    t_start(); t_byte(8'h05); t_byte(8'h80); t_byte(8'h5A);
    chk("R1 enable after skip", en_o, 8'h5A);

    // R9 unmapped write; R7 read-only id/status
    t_cmd(8'h82); t_byte(8'hFF); t_rdat("R9 unmapped read");
    chk_outs("R9 outs unchanged");
    t_cmd(8'h92); t_byte(8'h00); t_rdat("R7 id");
    chk("R7 id value", exp_rd('h12), 8'h44);

    // R6 interrupt flag
    t_cmd(8'h93); t_byte(8'hFF);
    t_int();
    t_rdat("R6 R7 status flag set");
    chk("R6 flag set", flag, 1'b1);
    t_cmd(8'hE5);
    chk("R6 other sf no clear", flag, 1'b1);
    t_cmd(8'hE6);
    chk("R6 clear", flag, 1'b0);
    t_rdat("R6 ptr unchanged status");

    // R5 R7 R8 results
    t_meas({16'hB1B0, 16'hA1A0, 16'h9190, 16'h8180});
    t_cmd(8'hB4);
    for (int i = 0; i < 2*NCH; i++) t_rdat("R5 result burst");
    t_cmd(8'h93); t_rdat("R7 valid bit");
    old_clear = m_res[0];
    t_cmd(8'hB4); t_rdat("R8 low");
    t_meas({16'h4444, 16'h3333, 16'h2222, 16'h1111});
    rd_en = 1'b1;
    #1 chk("R8 coherent high", rd_data, old_clear[15:8]);
    @(negedge clk); rd_en = 1'b0;
    m_sh[0] = old_clear[15:8]; m_ptr = m_ptr + 1'b1;

    // R10 gain codes
    for (int c = 0; c < 4; c++) begin
      t_cmd(8'h8F); t_byte(8'(c) | 8'hF0);
      chk("R10 gain", gain, gain_of(2'(c)));
    end

    // random mix, R12 readback
    for (int it = 0; it < 300; it++) begin
      int op;
      op = $urandom_range(0, 6);
      case (op)
        0: begin t_cmd(8'h80 | 8'($urandom_range(0, 31))); t_byte(8'($urandom)); end
        1: begin
             t_cmd(8'hA0 | 8'($urandom_range(0, 31)));
             repeat ($urandom_range(1, 3)) t_byte(8'($urandom));
           end
        2: begin
             t_cmd(($urandom_range(0, 1) ? 8'hA0 : 8'hC0) | 8'($urandom_range(0, 31)));
             repeat ($urandom_range(1, 4)) t_rdat("R12 random read");
           end
        3: t_meas({$urandom, $urandom});
        4: t_int();
        5: t_cmd($urandom_range(0, 1) ? 8'hE6 : 8'hE0 | 8'($urandom_range(0, 31)));
        default: begin
             t_cmd(8'h80 | 8'($urandom_range(0, 31)));
             t_rdat("R12 single read");
           end
      endcase
      if (it % 10 == 0) chk_outs("R12 random outs");
    end
    chk_outs("R12 final outs");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule